// File: doc/BRIEF.md
# Keyed Block Copy Engine

The engine moves bytes from one region of a byte-wide synchronous memory to another. Software loads a 16-bit source pointer, a 16-bit destination pointer, a 16-bit byte count and an 8-bit key, picks an addressing mode and pulses start. Every step reads one source byte and writes it to the destination, unless the byte equals the key. A byte that matches the key is skipped, so the key works as a transparent colour. After each step the pointers and the count advance according to the mode.

There are three keyed modes. The incrementing mode and the decrementing mode walk the source up or down while the destination always walks up. The pattern mode reads from an aligned 8-byte source window, indexed by the low destination bits, and so tiles a pattern across the destination. A fourth mode does one unkeyed copy. It then steps the low byte of the source and the high byte of the destination, each of which wraps within itself, and it reports flags as an 8-bit increment of that high byte would. The engine keeps a running count of T-states, using the cost that each kind of step carries.

Top module: `blk_copy_engine`

## Requirements
- R1: After reset, busy_o, done_o and mem_we_o are low, and src_o, dst_o, cnt_o, flags_o and tstates_o are all zero.
- R2: In mode 0 (incrementing), a step reads the byte at src, writes it to dst unless it equals the key, then adds 1 to src and dst and subtracts 1 from cnt.
- R3: In mode 1 (decrementing), a step reads at src and applies the same key rule, then subtracts 1 from src, adds 1 to dst and subtracts 1 from cnt.
- R4: In mode 2 (pattern), a step reads at {src[15:3], dst[2:0]} and applies the key rule. It then adds 1 to dst and subtracts 1 from cnt, and src never changes.
- R5: In modes 0 to 2, no byte equal to the key is ever written. A run in which every source byte matches the key leaves memory untouched.
- R6: In modes 0 to 2 with rep_i=1, stepping goes on while cnt is non-zero after its decrement. With rep_i=0 exactly one step runs. A single step that starts with cnt=0 leaves cnt=0xFFFF.
- R7: tstates_o is cleared when a run starts. Each step then adds to it: 21 for a step after which the run repeats, 16 for the final step or a single step, and 14 for a mode 3 step.
- R8: In mode 3 (word step), exactly one step runs and rep_i is ignored. The byte at src is always written to dst, even when it equals the key. src[7:0] then increments, wrapping within 8 bits. dst[15:8] increments, wrapping within 8 bits. cnt does not change.
- R9: A mode 3 step sets flags_o from an 8-bit increment of the old D=dst[15:8]. Bit 3 is the sign of D+1, bit 2 is set when D+1 is zero, bit 1 is set when D[3:0] was 0xF, and bit 0 is set when D was 0x7F. Modes 0 to 2 leave flags_o unchanged.
- R10: src and dst wrap modulo 65536 in every mode.
- R11: busy_o is high from the cycle after start_i is accepted until the run ends. done_o is then a one-cycle pulse with busy_o low. start_i is ignored while busy.
- R12: Each step is a read cycle followed by a write cycle. mem_we_o is high only in a write cycle. Read data is taken from the cycle after the read address is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when the engine is idle |
| mode_i | input | 2 | 0 incrementing, 1 decrementing, 2 pattern, 3 word step |
| rep_i | input | 1 | Repeat until the count is exhausted (modes 0 to 2) |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 16 | Initial byte count |
| key_i | input | 8 | Key byte that suppresses writes |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after the address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| cnt_o | output | 16 | Current count |
| flags_o | output | 4 | Sign, zero, half-carry and overflow from the word-step mode |
| tstates_o | output | 32 | T-states accumulated by the current run |

## Verification
Two things can land in the same write cycle: the suppression of a key-matching byte and the end of a repeating run. When both happen, the final step must give no write strobe, a done pulse and a 16-state charge rather than 21. The bench provokes this by placing the key byte last in the source of a repeating copy. It judges the outcome by the untouched destination byte, the final pointers and the exact T-state total, all taken from a reference model kept in the bench. A start pulse issued in the middle of a run, together with different operands, must leave that run's results intact.

// File: rtl/bce_pkg.sv
package bce_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        MD_INC  = 2'd0,
        MD_DEC  = 2'd1,
        MD_PAT  = 2'd2,
        MD_WORD = 2'd3
    } bce_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bce_state_e;
endpackage

// File: rtl/bce_addr_gen.sv
module bce_addr_gen
    import bce_pkg::*;
#(
    parameter int PAT_BITS = 3
) (
    input  bce_mode_e           mode_i,
    input  logic [ADDR_W-1:0]   src_i,
    input  logic [ADDR_W-1:0]   dst_i,
    output logic [ADDR_W-1:0]   rd_addr_o,
    output logic [ADDR_W-1:0]   src_next_o,
    output logic [ADDR_W-1:0]   dst_next_o
);
    localparam int HALF = ADDR_W / 2;

    logic [HALF-1:0] lo_inc;
    logic [HALF-1:0] hi_inc;

    assign lo_inc = src_i[HALF-1:0] + 1'b1;
    assign hi_inc = dst_i[ADDR_W-1:HALF] + 1'b1;

    always_comb begin
        rd_addr_o  = src_i;
        src_next_o = src_i;
        dst_next_o = dst_i + 1'b1;
        unique case (mode_i)
            MD_INC:  src_next_o = src_i + 1'b1;
            MD_DEC:  src_next_o = src_i - 1'b1;
            MD_PAT:  rd_addr_o  = {src_i[ADDR_W-1:PAT_BITS], dst_i[PAT_BITS-1:0]};
            MD_WORD: begin
                src_next_o = {src_i[ADDR_W-1:HALF], lo_inc};
                dst_next_o = {hi_inc, dst_i[HALF-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bce_inc_flags.sv
module bce_inc_flags
    import bce_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      val_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [W-1:0] sum;

    assign sum = val_i + 1'b1;

    always_comb begin
        flags_o[3] = sum[W-1];
        flags_o[2] = (sum == '0);
        flags_o[1] = (val_i[3:0] == 4'hF);
        flags_o[0] = (val_i == {1'b0, {(W-1){1'b1}}});
    end
endmodule

// File: rtl/bce_step_cost.sv
module bce_step_cost #(
    parameter int TS_W   = 32,
    parameter int T_REP  = 21,
    parameter int T_LAST = 16,
    parameter int T_WORD = 14
) (
    input  logic            word_i,
    input  logic            more_i,
    output logic [TS_W-1:0] cost_o
);
    always_comb begin
        if (word_i)      cost_o = TS_W'(T_WORD);
        else if (more_i) cost_o = TS_W'(T_REP);
        else             cost_o = TS_W'(T_LAST);
    end
endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
    import bce_pkg::*;
#(
    parameter int TS_W     = 32,
    parameter int T_REP    = 21,
    parameter int T_LAST   = 16,
    parameter int T_WORD   = 14,
    parameter int PAT_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic              rep_i,
    input  logic [15:0]       src_i,
    input  logic [15:0]       dst_i,
    input  logic [15:0]       cnt_i,
    input  logic [7:0]        key_i,
    output logic [15:0]       mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       src_o,
    output logic [15:0]       dst_o,
    output logic [15:0]       cnt_o,
    output logic [3:0]        flags_o,
    output logic [TS_W-1:0]   tstates_o
);
    localparam int HALF = ADDR_W / 2;

    typedef struct packed {
        bce_state_e           st;
        bce_mode_e            mode;
        logic                 rep;
        logic [ADDR_W-1:0]    src;
        logic [ADDR_W-1:0]    dst;
        logic [ADDR_W-1:0]    cnt;
        logic [DATA_W-1:0]    key;
        logic [FLAG_W-1:0]    flags;
        logic [TS_W-1:0]      ts;
        logic                 done;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0] rd_addr, src_nx, dst_nx, cnt_nx;
    logic [FLAG_W-1:0] word_flags;
    logic [TS_W-1:0]   step_cost;
    logic              is_word, more, hit;

    bce_addr_gen #(.PAT_BITS(PAT_BITS)) i_addr (
        .mode_i     (r_q.mode),
        .src_i      (r_q.src),
        .dst_i      (r_q.dst),
        .rd_addr_o  (rd_addr),
        .src_next_o (src_nx),
        .dst_next_o (dst_nx)
    );

    bce_inc_flags #(.W(HALF)) i_flags (
        .val_i   (r_q.dst[ADDR_W-1:HALF]),
        .flags_o (word_flags)
    );

    bce_step_cost #(
        .TS_W(TS_W), .T_REP(T_REP), .T_LAST(T_LAST), .T_WORD(T_WORD)
    ) i_cost (
        .word_i (is_word),
        .more_i (more),
        .cost_o (step_cost)
    );

    assign is_word = (r_q.mode == MD_WORD);
    assign cnt_nx  = is_word ? r_q.cnt : r_q.cnt - 1'b1;
    assign more    = !is_word && r_q.rep && (cnt_nx != '0);
    assign hit     = !is_word && (mem_rdata_i == r_q.key);

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        mem_addr_o  = rd_addr;
        mem_wdata_o = mem_rdata_i;
        mem_we_o    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_READ;
                    r_d.mode = bce_mode_e'(mode_i);
                    r_d.rep  = rep_i;
                    r_d.src  = src_i;
                    r_d.dst  = dst_i;
                    r_d.cnt  = cnt_i;
                    r_d.key  = key_i;
                    r_d.ts   = '0;
                end
            end
            ST_READ: r_d.st = ST_WRITE;
            ST_WRITE: begin
                mem_addr_o = r_q.dst;
                mem_we_o   = !hit;
                r_d.src    = src_nx;
                r_d.dst    = dst_nx;
                r_d.cnt    = cnt_nx;
                r_d.ts     = r_q.ts + step_cost;
                if (is_word) r_d.flags = word_flags;
                r_d.st     = more ? ST_READ : ST_IDLE;
                r_d.done   = !more;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: MD_INC, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign src_o     = r_q.src;
    assign dst_o     = r_q.dst;
    assign cnt_o     = r_q.cnt;
    assign flags_o   = r_q.flags;
    assign tstates_o = r_q.ts;
endmodule

// File: rtl/bce_chk.sv
module bce_chk #(
    parameter int TS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            mem_we,
    input logic [15:0]     src,
    input logic [15:0]     dst,
    input logic [15:0]     cnt,
    input logic [TS_W-1:0] ts
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(src) && $stable(dst) && $stable(cnt)));

    // R12
    we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R2
    we_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (dst != $past(dst)));

    // R7
    ts_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (ts >= $past(ts)));
endmodule

bind blk_copy_engine bce_chk #(.TS_W(TS_W)) i_bce_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .busy   (busy_o),
    .done   (done_o),
    .mem_we (mem_we_o),
    .src    (src_o),
    .dst    (dst_o),
    .cnt    (cnt_o),
    .ts     (tstates_o)
);

// File: tb/test_blk_copy_engine.sv
module test_blk_copy_engine;
    localparam int MEM_N = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        rep_i = 1'b0;
    logic [15:0] src_i = '0, dst_i = '0, cnt_i = '0;
    logic [7:0]  key_i = '0;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o;
    logic [7:0]  mem_rdata_i;
    logic        busy_o, done_o;
    logic [15:0] src_o, dst_o, cnt_o;
    logic [3:0]  flags_o;
    logic [31:0] tstates_o;

    int checks = 0;
    int failures = 0;

    logic [7:0] mem     [MEM_N];
    logic [7:0] ref_mem [MEM_N];
    logic [3:0] exp_flags = '0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        mem_rdata_i <= mem[mem_addr_o[11:0]];
        if (mem_we_o) mem[mem_addr_o[11:0]] <= mem_wdata_o;
    end

    blk_copy_engine i_blk_copy_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .rep_i(rep_i),
        .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i), .key_i(key_i),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flags_o),
        .tstates_o(tstates_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input int base, input int n, input logic [7:0] v);
        for (int i = 0; i < n; i++) mem[(base + i) % MEM_N] = v;
    endtask

    // Runs one job and compares everything against a bench-side model.
    task automatic run(input string req, input logic [1:0] md, input logic rp,
                       input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                       input logic [7:0] k, input bit poke);
        logic [15:0] ms, md_, mc, a;
        logic [31:0] mt;
        logic [7:0]  b, dh, nd;
        int          cyc, bad;
        bit          fin;
        for (int i = 0; i < MEM_N; i++) ref_mem[i] = mem[i];
        ms = s; md_ = d; mc = c; mt = 0; fin = 0;
        while (!fin) begin
            if (md == 2'd3) begin
                ref_mem[md_[11:0]] = ref_mem[ms[11:0]];
                dh = md_[15:8];
                nd = dh + 8'd1;
                exp_flags = {nd[7], nd == 8'h00, dh[3:0] == 4'hF, dh == 8'h7F};
                ms = {ms[15:8], ms[7:0] + 8'd1};
                md_ = {nd, md_[7:0]};
                mt += 14;
                fin = 1;
            end else begin
                a = (md == 2'd2) ? {ms[15:3], md_[2:0]} : ms;
                b = ref_mem[a[11:0]];
                if (b != k) ref_mem[md_[11:0]] = b;
                md_ = md_ + 16'd1;
                if (md == 2'd0) ms = ms + 16'd1;
                if (md == 2'd1) ms = ms - 16'd1;
                mc = mc - 16'd1;
                if (rp && mc != 0) mt += 21;
                else begin mt += 16; fin = 1; end
            end
        end
        @(negedge clk);
        mode_i = md; rep_i = rp; src_i = s; dst_i = d; cnt_i = c; key_i = k; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, {req, " R11 busy after start"}, busy_o, 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            src_i = 16'h0ABC; dst_i = 16'h0DEF; cnt_i = 16'h0003; mode_i = 2'd3; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (done_o !== 1'b1 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done_o === 1'b1 && busy_o === 1'b0, {req, " R11 done pulse idle"}, {busy_o, done_o}, 1);
        chk(src_o === ms, {req, " src"}, src_o, ms);
        chk(dst_o === md_, {req, " dst"}, dst_o, md_);
        chk(cnt_o === mc, {req, " cnt"}, cnt_o, mc);
        chk(tstates_o === mt, {req, " R7 tstates"}, tstates_o, mt);
        chk(flags_o === exp_flags, {req, " R9 flags"}, flags_o, exp_flags);
        bad = 0;
        for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, {req, " memory image"}, bad, 0);
        @(negedge clk);
        chk(done_o === 1'b0, {req, " R11 done single cycle"}, done_o, 0);
    endtask

    task automatic t_reset();
        chk(busy_o === 1'b0 && done_o === 1'b0 && mem_we_o === 1'b0, "R1 control low",
            {busy_o, done_o, mem_we_o}, 0);
        chk(src_o === 0 && dst_o === 0 && cnt_o === 0, "R1 pointers zero", {src_o, dst_o}, 0);
        chk(flags_o === 0 && tstates_o === 0, "R1 flags and tstates zero", tstates_o, 0);
    endtask

    task automatic t_inc_key_last();
        fill(16'h200, 8, 8'h5A);
        mem[16'h100] = 8'h11; mem[16'h101] = 8'hAA; mem[16'h102] = 8'h22;
        mem[16'h103] = 8'h33; mem[16'h104] = 8'hAA;
        run("R2 R5 R6 inc repeat key-last", 2'd0, 1'b1, 16'h0100, 16'h0200, 16'd5, 8'hAA, 0);
        chk(mem[16'h204] === 8'h5A, "R5 final key byte not written", mem[16'h204], 8'h5A);
    endtask

    task automatic t_dec_wrap();
        for (int i = 0; i < 4; i++) mem[i] = 8'h40 + 8'(i);
        mem[MEM_N-1] = 8'h77; mem[MEM_N-2] = 8'h66;
        run("R3 R10 dec repeat src wrap", 2'd1, 1'b1, 16'h0002, 16'h0300, 16'd5, 8'h41, 0);
    endtask

    task automatic t_pattern();
        for (int i = 0; i < 8; i++) mem[16'h0300 + i] = 8'hC0 + 8'(i);
        mem[16'h0303] = 8'h00;
        run("R4 pattern repeat", 2'd2, 1'b1, 16'h0305, 16'h0406, 16'd11, 8'h00, 0);
    endtask

    task automatic t_all_key();
        fill(16'h500, 6, 8'hE7);
        fill(16'h600, 6, 8'h01);
        run("R5 all bytes match key", 2'd0, 1'b1, 16'h0500, 16'h0600, 16'd6, 8'hE7, 0);
    endtask

    task automatic t_single();
        mem[16'h700] = 8'h9C;
        run("R6 single step", 2'd0, 1'b0, 16'h0700, 16'h0710, 16'd3, 8'h00, 0);
        run("R6 single step count zero wraps", 2'd1, 1'b0, 16'h0700, 16'h0720, 16'd0, 8'h00, 0);
    endtask

    task automatic t_word();
        mem[16'h02FF] = 8'h3C;
        run("R8 R9 word step key ignored", 2'd3, 1'b1, 16'h02FF, 16'h7F34, 16'd9, 8'h3C, 0);
        run("R8 R9 word step D wraps", 2'd3, 1'b0, 16'h0210, 16'hFF08, 16'd2, 8'h00, 0);
    endtask

    task automatic t_dst_wrap();
        fill(16'h800, 4, 8'h21);
        run("R10 dst wraps", 2'd0, 1'b1, 16'h0800, 16'hFFFE, 16'd3, 8'h00, 0);
    endtask

    task automatic t_busy_start();
        for (int i = 0; i < 8; i++) mem[16'h900 + i] = 8'h10 + 8'(i);
        run("R11 start ignored while busy", 2'd0, 1'b1, 16'h0900, 16'h0A00, 16'd8, 8'h12, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inc_key_last();
        t_dec_wrap();
        t_pattern();
        t_all_key();
        t_single();
        t_word();
        t_dst_wrap();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule